// File: doc/BRIEF.md
# Nibble Register Serial Link Master

This block is the master end of a three-wire bit-serial link to a clock-calendar device. The wires are a serial clock that idles high, one data line driven through a separate output enable, and a data input returned from the device. A host asks for one register access at a time. Each request is a strobe with a read/write select, a 4-bit register number and a 4-bit write value. The block turns the request into one or two byte transfers on the link and then reports completion with a single-cycle pulse. On a read, that pulse comes with the returned nibble.

Each command byte carries three control flags in its upper half, placed at fixed bit positions that the device decodes: a read flag, an address-phase flag and a data-phase flag. The lower half carries the register number or the data value. The half-period of the serial clock is derived at elaboration from two parameters, the target half-period in nanoseconds and the system clock period in picoseconds. The default gives 70 cycles at 100 MHz. Chip-enable framing is left to a sequencer above this block.

Top module: `nib3w_master`

## Requirements
- R1: `sclk_o` is high whenever no byte is being shifted. Each bit slot drives it low for exactly HALF_CYC system cycles, where HALF_CYC = ceil(HALF_NS*1000/CLK_PS).
- R2: Each bit slot has three parts: one setup cycle with `sclk_o` high, in which the new data value appears; then HALF_CYC cycles high; then HALF_CYC cycles low. After the eighth slot the clock stays high for one more HALF_CYC tail before the byte ends.
- R3: Bytes go out most significant bit first, with exactly eight low pulses per byte. `sdo_o` is stable throughout every low phase.
- R4: In a write byte, `sdo_oe_o` rises one cycle after the first bit value is placed on `sdo_o`. It falls at the end of the tail half-period. It stays low for the whole of a read byte.
- R5: In a read byte, `sdi_i` is sampled on the last cycle of each high half-period, just before the clock falls. The eight samples are collected and only their low four bits are returned on `rdata_o`.
- R6: In a command byte, bit 6 is the read flag, bit 5 the address-phase flag and bit 4 the data-phase flag. Bit 7 is zero and bits 3:0 hold the address or the data.
- R7: A read sends 0x60 | addr, then runs one eight-pulse read byte.
- R8: A write sends 0x20 | addr, then 0x10 | data, with the data masked to four bits.
- R9: A request is accepted when `req_i` is high and `busy_o` is low. Timing after the accepting edge:
  - `busy_o` rises in the cycle after that edge.
  - The first setup cycle starts one cycle later.
  - Two idle cycles separate the two bytes.
  - `done_o` is a single-cycle pulse, with `busy_o` already low, two cycles after the second tail ends.
- R10: A request raised while `busy_o` is high is ignored: it changes neither the bytes sent nor the completion timing.
- R11: After reset, `sclk_o` is high, `sdo_oe_o` and `busy_o` are low, `done_o` is low and the bit counter is zero.
- R12: `rdata_o` changes only when a read completes. It holds its value through write transactions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Request strobe |
| rd_i | input | 1 | 1 = register read, 0 = register write |
| addr_i | input | 4 | Register number |
| wdata_i | input | 4 | Write nibble |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 4 | Nibble returned by the last read |
| sclk_o | output | 1 | Serial clock, idles high |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for the data line |
| sdi_i | input | 1 | Serial data in |

## Verification
The assertions assume that `sdi_i` is stable during the last high cycle before each falling clock. They also assume that the host may raise `req_i` at any time, including while a transaction is running. The bench drives `sdi_i` half a system cycle after each edge and changes it only at bit-slot boundaries. It deliberately raises stray requests with different field values in the middle of a transfer. The device's reply bytes carry non-zero upper halves, so that the masking to four bits is visible on `rdata_o`.

// File: rtl/nib3w_pkg.sv
// Shared constants, state types and command-byte builders for the serial link master.
// Assumes a byte of eight bits and a nibble payload of four bits.
package nib3w_pkg;
    localparam int BYTE_W  = 8;
    localparam int NIB_W   = 4;
    localparam int BIT_CW  = $clog2(BYTE_W);
    localparam int FLAG_RD = 6;
    localparam int FLAG_AD = 5;
    localparam int FLAG_DT = 4;

    typedef enum logic [2:0] {
        ENG_IDLE,
        ENG_SETUP,
        ENG_HIGH,
        ENG_LOW,
        ENG_TAIL
    } eng_state_t;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_CMD,
        SEQ_ARG
    } seq_state_t;

    // Builds the address-phase byte; the read flag is set for register reads.
    function automatic logic [BYTE_W-1:0] addr_byte(input logic rd, input logic [NIB_W-1:0] a);
        logic [BYTE_W-1:0] b;
        b = '0;
        b[FLAG_AD] = 1'b1;
        b[FLAG_RD] = rd;
        b[NIB_W-1:0] = a;
        return b;
    endfunction

    // Builds the data-phase byte carrying one nibble.
    function automatic logic [BYTE_W-1:0] data_byte(input logic [NIB_W-1:0] d);
        logic [BYTE_W-1:0] b;
        b = '0;
        b[FLAG_DT] = 1'b1;
        b[NIB_W-1:0] = d;
        return b;
    endfunction
endpackage

// File: rtl/nib3w_halfper.sv
// Half-period timer: counts system cycles while enabled and flags the last cycle
// of each HALF_CYC-long window. Assumes HALF_CYC >= 1; restarts from zero when idle.
module nib3w_halfper #(
    parameter int HALF_CYC = 70
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic last_o
);
    localparam int CW = $clog2(HALF_CYC + 1);
    localparam logic [CW-1:0] LAST_VAL = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt_q;

    assign last_o = run_i && (cnt_q == LAST_VAL);

    // Count cycles in the current window; wrap at the last one or when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i || last_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/nib3w_byte_eng.sv
// Byte engine: shifts one byte MSB first on the serial link, either driving it
// (write) or sampling the input line (read). Per bit: setup cycle, high half,
// low half; one extra high half after bit eight. Assumes start only while idle.
module nib3w_byte_eng
    import nib3w_pkg::*;
#(
    parameter int HALF_CYC = 70
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              wr_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              sdi_i,
    output logic              sclk_o,
    output logic              sdo_o,
    output logic              oe_o,
    output logic [NIB_W-1:0]  rx_o,
    output logic              done_o
);
    localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(BYTE_W - 1);

    eng_state_t        st_q;
    logic [BYTE_W-1:0] sr_q;
    logic [BIT_CW-1:0] bit_q;
    logic              wr_q;
    logic              oe_q;
    logic              done_q;
    logic              timer_run;
    logic              half_last;

    assign timer_run = (st_q == ENG_HIGH) || (st_q == ENG_LOW) || (st_q == ENG_TAIL);

    nib3w_halfper #(.HALF_CYC(HALF_CYC)) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (timer_run),
        .last_o (half_last)
    );

    // Walk the bit slots, shift data and manage the output enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ENG_IDLE;
            sr_q   <= '0;
            bit_q  <= '0;
            wr_q   <= 1'b0;
            oe_q   <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                ENG_IDLE: begin
                    if (start_i) begin
                        st_q  <= ENG_SETUP;
                        sr_q  <= byte_i;
                        wr_q  <= wr_i;
                        bit_q <= '0;
                    end
                end
                ENG_SETUP: begin
                    st_q <= ENG_HIGH;
                    if (wr_q) oe_q <= 1'b1;
                end
                ENG_HIGH: begin
                    if (half_last) begin
                        st_q <= ENG_LOW;
                        if (!wr_q) sr_q <= {sr_q[BYTE_W-2:0], sdi_i};
                    end
                end
                ENG_LOW: begin
                    if (half_last) begin
                        if (bit_q == LAST_BIT) begin
                            st_q <= ENG_TAIL;
                        end else begin
                            st_q  <= ENG_SETUP;
                            bit_q <= bit_q + 1'b1;
                            if (wr_q) sr_q <= {sr_q[BYTE_W-2:0], 1'b0};
                        end
                    end
                end
                ENG_TAIL: begin
                    if (half_last) begin
                        st_q   <= ENG_IDLE;
                        oe_q   <= 1'b0;
                        done_q <= 1'b1;
                    end
                end
                default: st_q <= ENG_IDLE;
            endcase
        end
    end

    assign sclk_o = (st_q != ENG_LOW);
    assign sdo_o  = sr_q[BYTE_W-1];
    assign oe_o   = oe_q;
    assign rx_o   = sr_q[NIB_W-1:0];
    assign done_o = done_q;
endmodule

// File: rtl/nib3w_seq.sv
// Transaction sequencer: accepts one host request while idle, issues the
// address byte then the data or read byte, and returns a done pulse.
// Assumes the byte engine signals done for one cycle per byte.
module nib3w_seq
    import nib3w_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              rd_i,
    input  logic [NIB_W-1:0]  addr_i,
    input  logic [NIB_W-1:0]  wdata_i,
    input  logic              eng_done_i,
    input  logic [NIB_W-1:0]  eng_rx_i,
    output logic              eng_start_o,
    output logic              eng_wr_o,
    output logic [BYTE_W-1:0] eng_byte_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [NIB_W-1:0]  rdata_o
);
    seq_state_t        st_q;
    logic              rd_q;
    logic [NIB_W-1:0]  wd_q;
    logic              start_q;
    logic              wr_q;
    logic [BYTE_W-1:0] byte_q;
    logic              busy_q;
    logic              done_q;
    logic [NIB_W-1:0]  rdata_q;

    // Step through the two byte phases of a register access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= SEQ_IDLE;
            rd_q    <= 1'b0;
            wd_q    <= '0;
            start_q <= 1'b0;
            wr_q    <= 1'b0;
            byte_q  <= '0;
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            start_q <= 1'b0;
            done_q  <= 1'b0;
            case (st_q)
                SEQ_IDLE: begin
                    if (req_i) begin
                        st_q    <= SEQ_CMD;
                        rd_q    <= rd_i;
                        wd_q    <= wdata_i;
                        busy_q  <= 1'b1;
                        start_q <= 1'b1;
                        wr_q    <= 1'b1;
                        byte_q  <= addr_byte(rd_i, addr_i);
                    end
                end
                SEQ_CMD: begin
                    if (eng_done_i) begin
                        st_q    <= SEQ_ARG;
                        start_q <= 1'b1;
                        wr_q    <= !rd_q;
                        byte_q  <= rd_q ? '0 : data_byte(wd_q);
                    end
                end
                SEQ_ARG: begin
                    if (eng_done_i) begin
                        st_q   <= SEQ_IDLE;
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                        if (rd_q) rdata_q <= eng_rx_i;
                    end
                end
                default: st_q <= SEQ_IDLE;
            endcase
        end
    end

    assign eng_start_o = start_q;
    assign eng_wr_o    = wr_q;
    assign eng_byte_o  = byte_q;
    assign busy_o      = busy_q;
    assign done_o      = done_q;
    assign rdata_o     = rdata_q;
endmodule

// File: rtl/nib3w_master.sv
// Top of the nibble-register serial link master: sequencer plus byte engine.
// Assumes one outstanding request; chip-enable framing lives outside.
// The half-period in cycles is derived from HALF_NS and CLK_PS, rounded up.
module nib3w_master #(
    parameter int HALF_NS = 700,
    parameter int CLK_PS  = 10000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_i,
    input  logic       rd_i,
    input  logic [3:0] addr_i,
    input  logic [3:0] wdata_i,
    output logic       busy_o,
    output logic       done_o,
    output logic [3:0] rdata_o,
    output logic       sclk_o,
    output logic       sdo_o,
    output logic       sdo_oe_o,
    input  logic       sdi_i
);
    import nib3w_pkg::*;

    localparam int HALF_RAW = (HALF_NS * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int HALF_CYC = (HALF_RAW < 1) ? 1 : HALF_RAW;

    logic              eng_start;
    logic              eng_wr;
    logic [BYTE_W-1:0] eng_byte;
    logic              eng_done;
    logic [NIB_W-1:0]  eng_rx;

    nib3w_seq seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req_i),
        .rd_i        (rd_i),
        .addr_i      (addr_i),
        .wdata_i     (wdata_i),
        .eng_done_i  (eng_done),
        .eng_rx_i    (eng_rx),
        .eng_start_o (eng_start),
        .eng_wr_o    (eng_wr),
        .eng_byte_o  (eng_byte),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .rdata_o     (rdata_o)
    );

    nib3w_byte_eng #(.HALF_CYC(HALF_CYC)) eng_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (eng_start),
        .wr_i    (eng_wr),
        .byte_i  (eng_byte),
        .sdi_i   (sdi_i),
        .sclk_o  (sclk_o),
        .sdo_o   (sdo_o),
        .oe_o    (sdo_oe_o),
        .rx_o    (eng_rx),
        .done_o  (eng_done)
    );
endmodule

// File: rtl/nib3w_master_chk.sv
// Checker for the serial link master, watching ports only; bound to the top below.
// Assumes synchronous active-low reset; the low-phase window is tracked by a counter.
module nib3w_master_chk #(
    parameter int HALF_NS = 700,
    parameter int CLK_PS  = 10000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       busy_o,
    input logic       done_o,
    input logic [3:0] rdata_o,
    input logic       sclk_o,
    input logic       sdo_o,
    input logic       sdo_oe_o
);
    localparam int HALF_RAW = (HALF_NS * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int HALF_CYC = (HALF_RAW < 1) ? 1 : HALF_RAW;

    logic [31:0] low_run;

    // Count how many consecutive cycles the serial clock has been low.
    always_ff @(posedge clk) begin
        if (!rst_n)       low_run <= '0;
        else if (sclk_o)  low_run <= '0;
        else              low_run <= low_run + 1;
    end

    a_r1_idle_clock_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> sclk_o);
    a_r1_low_phase_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_o |-> (low_run < 32'(HALF_CYC)));
    a_r3_data_stable_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk_o && $past(!sclk_o)) |-> $stable(sdo_o));
    a_r4_oe_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !sdo_oe_o);
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r9_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));
    a_r12_rdata_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(rdata_o));
endmodule

bind nib3w_master nib3w_master_chk #(.HALF_NS(HALF_NS), .CLK_PS(CLK_PS)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .rdata_o  (rdata_o),
    .sclk_o   (sclk_o),
    .sdo_o    (sdo_o),
    .sdo_oe_o (sdo_oe_o)
);

// File: tb/nib3w_master_tb_top.sv
// Bench: queue-based per-cycle reference of the link waveform, compared every cycle.
module nib3w_master_tb_top;
    localparam int HALF_NS = 700;
    localparam int CLK_PS  = 10000;
    localparam int H       = (HALF_NS * 1000 + CLK_PS - 1) / CLK_PS;

    typedef struct packed {
        logic       busy;
        logic       done;
        logic       sclk;
        logic       oe;
        logic       sdo_chk;
        logic       sdo;
        logic       sdi;
        logic       rd_chk;
        logic [3:0] rdata;
    } exp_t;

    logic       clk;
    logic       rst_n;
    logic       req_i;
    logic       rd_i;
    logic [3:0] addr_i;
    logic [3:0] wdata_i;
    logic       busy_o;
    logic       done_o;
    logic [3:0] rdata_o;
    logic       sclk_o;
    logic       sdo_o;
    logic       sdo_oe_o;
    logic       sdi_i;

    int   total;
    int   bad;
    exp_t q[$];
    logic cap[$];
    logic [3:0] last_rd;
    logic prev_sclk;

    nib3w_master #(.HALF_NS(HALF_NS), .CLK_PS(CLK_PS)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (req_i),
        .rd_i     (rd_i),
        .addr_i   (addr_i),
        .wdata_i  (wdata_i),
        .busy_o   (busy_o),
        .done_o   (done_o),
        .rdata_o  (rdata_o),
        .sclk_o   (sclk_o),
        .sdo_o    (sdo_o),
        .sdo_oe_o (sdo_oe_o),
        .sdi_i    (sdi_i)
    );

    initial begin
        clk = 1'b0;
        forever #5 clk = ~clk;
    end

    task automatic chk(input logic ok, input string tag, input string what,
                       input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, expv);
        end
    endtask

    function automatic exp_t idle_e(input logic busy);
        exp_t e;
        e = '0;
        e.busy = busy;
        e.sclk = 1'b1;
        return e;
    endfunction

    // One byte: per bit a setup cycle, H high, H low; then an H-cycle high tail (R2).
    task automatic push_byte(input logic [7:0] b, input logic wr, input logic [7:0] reply);
        exp_t e;
        for (int k = 0; k < 8; k++) begin
            for (int p = 0; p <= 2 * H; p++) begin
                e = idle_e(1'b1);
                e.sclk    = (p <= H);
                e.oe      = wr && !(k == 0 && p == 0);
                e.sdo_chk = e.oe;
                e.sdo     = b[7-k];
                e.sdi     = wr ? 1'b0 : reply[7-k];
                q.push_back(e);
            end
        end
        for (int t = 0; t < H; t++) begin
            e = idle_e(1'b1);
            e.oe      = wr;
            e.sdo_chk = wr;
            e.sdo     = b[0];
            q.push_back(e);
        end
    endtask

    // Whole transaction timeline after the accepting edge (R7, R8, R9).
    task automatic plan_txn(input logic rd, input logic [3:0] a, input logic [3:0] d,
                            input logic [7:0] reply);
        exp_t e;
        q.push_back(idle_e(1'b1));
        push_byte({1'b0, rd, 1'b1, 1'b0, a}, 1'b1, 8'h00);
        q.push_back(idle_e(1'b1));
        q.push_back(idle_e(1'b1));
        push_byte(rd ? 8'h00 : {4'h1, d}, !rd, reply);
        q.push_back(idle_e(1'b1));
        if (rd) last_rd = reply[3:0];
        e = idle_e(1'b0);
        e.done   = 1'b1;
        e.rd_chk = 1'b1;
        e.rdata  = last_rd;
        q.push_back(e);
    endtask

    // Per-cycle comparison against the reference queue, plus a bit monitor.
    always @(negedge clk) begin
        exp_t e;
        if (rst_n) begin
            e = (q.size() > 0) ? q.pop_front() : idle_e(1'b0);
            chk(sclk_o == e.sclk, "R1,R2", "sclk", sclk_o, e.sclk);
            chk(sdo_oe_o == e.oe, "R4", "oe", sdo_oe_o, e.oe);
            chk(busy_o == e.busy, "R9", "busy", busy_o, e.busy);
            chk(done_o == e.done, "R9", "done", done_o, e.done);
            if (e.sdo_chk) chk(sdo_o == e.sdo, "R3", "sdo", sdo_o, e.sdo);
            if (e.rd_chk) chk(rdata_o == e.rdata, "R5,R12", "rdata", rdata_o, e.rdata);
            sdi_i <= e.sdi;
            if (prev_sclk && !sclk_o && sdo_oe_o) cap.push_back(sdo_o);
            prev_sclk <= sclk_o;
        end
    end

    task automatic run_txn(input logic rd, input logic [3:0] a, input logic [3:0] d,
                           input logic [7:0] reply, input logic poke);
        logic [7:0] got;
        logic [7:0] want;
        @(negedge clk);
        #1;
        cap.delete();
        req_i = 1'b1; rd_i = rd; addr_i = a; wdata_i = d;
        plan_txn(rd, a, d, reply);
        @(negedge clk);
        #1;
        req_i = 1'b0;
        if (poke) begin
            // R10: stray request with different fields while busy
            repeat (50) @(negedge clk);
            #1;
            req_i = 1'b1; rd_i = !rd; addr_i = ~a; wdata_i = ~d;
            @(negedge clk);
            #1;
            req_i = 1'b0;
        end
        wait (q.size() == 0);
        repeat (2) @(negedge clk);
        // R6: flags at bits 6..4, payload in bits 3..0, MSB first on the line
        chk(cap.size() == (rd ? 8 : 16), poke ? "R10" : "R3", "captured bits",
            cap.size(), rd ? 8 : 16);
        if (cap.size() >= 8) begin
            for (int i = 0; i < 8; i++) got[7-i] = cap[i];
            want = {1'b0, rd, 1'b1, 1'b0, a};
            chk(got == want, rd ? "R7" : "R8", "address byte", got, want);
        end
        if (!rd && cap.size() == 16) begin
            for (int i = 0; i < 8; i++) got[7-i] = cap[8+i];
            want = {4'h1, d};
            chk(got == want, "R8", "data byte", got, want);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R9 watchdog act=%0h exp=%0h", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        total = 0; bad = 0; last_rd = 4'h0; prev_sclk = 1'b1;
        rst_n = 1'b0; req_i = 1'b0; rd_i = 1'b0; addr_i = '0; wdata_i = '0; sdi_i = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R11: reset state seen at the ports
        chk(sclk_o == 1'b1, "R11", "sclk after reset", sclk_o, 1);
        chk(sdo_oe_o == 1'b0, "R11", "oe after reset", sdo_oe_o, 0);
        chk(busy_o == 1'b0 && done_o == 1'b0, "R11", "busy/done after reset",
            {busy_o, done_o}, 0);
        chk(rdata_o == 4'h0, "R11", "rdata after reset", rdata_o, 0);
        run_txn(1'b1, 4'hE, 4'h0, 8'hA5, 1'b0);
        run_txn(1'b0, 4'h7, 4'hC, 8'h00, 1'b0);
        run_txn(1'b0, 4'h0, 4'hF, 8'h00, 1'b1);
        run_txn(1'b1, 4'hF, 4'h3, 8'h3C, 1'b1);
        run_txn(1'b1, 4'h0, 4'h0, 8'hFF, 1'b0);
        run_txn(1'b0, 4'hA, 4'h0, 8'h00, 1'b0);
        // R12: write left the last read nibble in place
        chk(rdata_o == 4'hF, "R12", "rdata after write", rdata_o, 4'hF);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule